// File: doc/BRIEF.md
# Serial port control and interrupt register

This block is the control word of a synchronous serial port. Software writes one 32-bit word through a simple write strobe and reads it back on a data bus that always shows the current contents. The stored fields go straight to the transmit and receive engines as configuration: enables, clock edge selection, bit order, frame length in slots and the mode of two auxiliary pins.

Two action bits at the top of the word form a combined soft reset. Setting only one of them does nothing. Setting both in one write restores the whole word to its power-on value and raises a one-cycle reset pulse for the rest of the port. The block also merges six status flags from the engines into one interrupt request. There is a transmit group of three flags and a receive group of three flags, and each group has its own enable bit in the word. When a pin's mode field selects general-purpose output, that pin is driven from a value bit.

Top module: `sport_ctl`

## Requirements
- R1: After hardware reset the read data is 0x00F00000, and soft_rst, irq and both pin_oe bits are 0.
- R2: A write that does not set both bits 31 and 30 stores bits 29:12. Bits 31:30 and 11:0 always read as 0, and without a write the contents hold.
- R3: A write with bits 31 and 30 both 1 sets the word back to 0x00F00000 at the next clock edge. soft_rst is 1 for the one cycle after that edge, then returns to 0 unless the same write is repeated.
- R4: A write with exactly one of bits 31 and 30 set gives no soft_rst pulse and stores bits 29:12 like any other write.
- R5: tx_en follows bit 29 and rx_en follows bit 28. tx_clk_pol follows bit 27 and rx_clk_pol follows bit 26. tx_lsb_first follows bit 25 and rx_lsb_first follows bit 24.
- R6: frame_slots equals field 15:12, except that a field of 0 gives 16.
- R7: pin1_mode is bits 23:22 and pin2_mode is bits 21:20. Mode 2'b01 sets pin_oe[0] (pin 1) or pin_oe[1] (pin 2), and the pin's pin_out then follows bit 19 (pin 1) or bit 18 (pin 2). Any other mode gives pin_oe = 0 and pin_out = 0 for that pin.
- R8: tx_flags is {framing error, underrun, data empty} in bits 2:0. With bit 17 set, any high tx_flags bit raises irq in the same cycle. With bit 17 clear, tx_flags have no effect.
- R9: rx_flags is {framing error, overrun, data full} in bits 2:0. With bit 16 set, any high rx_flags bit raises irq in the same cycle. With bit 16 clear, rx_flags have no effect.
- R10: irq is the OR of the gated transmit group and the gated receive group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Write strobe for the control word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Current control word |
| tx_flags | input | 3 | Transmit status flags {framing, underrun, empty} |
| rx_flags | input | 3 | Receive status flags {framing, overrun, full} |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| tx_clk_pol | output | 1 | Transmit clock edge select |
| rx_clk_pol | output | 1 | Receive clock edge select |
| tx_lsb_first | output | 1 | Transmit bit order, 1 = LSB first |
| rx_lsb_first | output | 1 | Receive bit order, 1 = LSB first |
| frame_slots | output | 5 | Frame length in slots, 1 to 16 |
| pin1_mode | output | 2 | Mode field of auxiliary pin 1 |
| pin2_mode | output | 2 | Mode field of auxiliary pin 2 |
| pin_oe | output | 2 | Output enable per pin, bit 0 = pin 1 |
| pin_out | output | 2 | Output value per pin, bit 0 = pin 1 |
| soft_rst | output | 1 | One-cycle port-wide soft reset pulse |
| irq | output | 1 | Combined interrupt request |

## Verification
The combined soft reset and the interrupt gating can act in the same cycle. A reset write clears both group enables, so an interrupt that is pending when the reset write arrives must drop on the same edge at which soft_rst rises. The bench provokes this by enabling the transmit group and holding a transmit flag high, then issuing the dual-bit write with the flag still high. It then expects soft_rst = 1, irq = 0 and the read data at its power-on value in that one sampled cycle.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int CTL_W    = 32;
    localparam int BIT_TRST = 31;
    localparam int BIT_RRST = 30;
    localparam int FLD_HI   = 29;
    localparam int FLD_LO   = 12;
    localparam int FS_W     = 4;
    localparam int MODE_W   = 2;

    // Field layout follows bits 29 down to 12 of the control word.
    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic              tx_pol;
        logic              rx_pol;
        logic              tx_lsb;
        logic              rx_lsb;
        logic [MODE_W-1:0] p1_mode;
        logic [MODE_W-1:0] p2_mode;
        logic              p1_val;
        logic              p2_val;
        logic              tx_ie;
        logic              rx_ie;
        logic [FS_W-1:0]   fsize;
    } ctl_fields_t;

    localparam logic [CTL_W-1:0] CTL_RESET    = 32'h00F0_0000;
    localparam ctl_fields_t      RESET_FIELDS = ctl_fields_t'(CTL_RESET[FLD_HI:FLD_LO]);

    typedef struct packed {
        ctl_fields_t fields;
        logic        srst;
    } ctl_state_t;

    function automatic logic [FS_W:0] decode_slots(input logic [FS_W-1:0] f);
        return (f == '0) ? {1'b1, {FS_W{1'b0}}} : {1'b0, f};
    endfunction

endpackage

// File: rtl/sport_ctl_regfile.sv
module sport_ctl_regfile
    import sport_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wdata,
    output ctl_fields_t      fields,
    output logic             srst_pulse
);

    ctl_state_t state_d, state_q;
    logic       dual_rst;
    logic       unused_low_bits;

    assign unused_low_bits = ^wdata[FLD_LO-1:0];
    assign dual_rst        = wdata[BIT_TRST] && wdata[BIT_RRST];

    always_comb begin
        state_d      = state_q;
        state_d.srst = 1'b0;
        if (wr_en) begin
            if (dual_rst) begin
                state_d.fields = RESET_FIELDS;
                state_d.srst   = 1'b1;
            end else begin
                state_d.fields = ctl_fields_t'(wdata[FLD_HI:FLD_LO]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{fields: RESET_FIELDS, srst: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign fields     = state_q.fields;
    assign srst_pulse = state_q.srst;

    // R3: dual-bit write restores the word and raises the pulse
    a_r3_dual_write_resets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dual_rst) |=> (srst_pulse && fields == RESET_FIELDS));

    // R3: pulse lasts one cycle unless re-requested
    a_r3_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (srst_pulse && !(wr_en && dual_rst)) |=> !srst_pulse);

    // R4: a single action bit never pulses
    a_r4_single_bit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wdata[BIT_TRST] != wdata[BIT_RRST])) |=> !srst_pulse);

    // R2: contents hold without a write
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(fields) && !srst_pulse));

endmodule

// File: rtl/sport_irq_merge.sv
module sport_irq_merge #(
    parameter int N_FLAGS = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_ie,
    input  logic               rx_ie,
    input  logic [N_FLAGS-1:0] tx_flags,
    input  logic [N_FLAGS-1:0] rx_flags,
    output logic               irq
);

    logic tx_req, rx_req;

    always_comb begin
        tx_req = tx_ie && (|tx_flags);
        rx_req = rx_ie && (|rx_flags);
        irq    = tx_req || rx_req;
    end

    // R8 / R9: both groups masked means no request
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_ie && !rx_ie) |-> !irq);

    // R10: an enabled receive flag always reaches the output
    a_r10_rx_reaches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ie && (|rx_flags)) |-> irq);

endmodule

// File: rtl/sport_gpo_pins.sv
module sport_gpo_pins #(
    parameter int          N_PINS   = 2,
    parameter int          MODE_W   = 2,
    parameter logic [1:0]  GPO_MODE = 2'b01
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_PINS*MODE_W-1:0] mode_vec,
    input  logic [N_PINS-1:0]        val_vec,
    output logic [N_PINS-1:0]        oe,
    output logic [N_PINS-1:0]        out
);

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [MODE_W-1:0] mode;
        assign mode = mode_vec[p*MODE_W +: MODE_W];

        always_comb begin
            oe[p]  = (mode == MODE_W'(GPO_MODE));
            out[p] = oe[p] && val_vec[p];
        end

        // R7: pin stays undriven outside general-purpose output mode
        a_r7_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_vec[p*MODE_W +: MODE_W] != MODE_W'(GPO_MODE)) |-> (!oe[p] && !out[p]));
    end

endmodule

// File: rtl/sport_ctl.sv
module sport_ctl
    import sport_pkg::*;
#(
    parameter int         N_FLAGS  = 3,
    parameter logic [1:0] GPO_MODE = 2'b01
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTL_W-1:0]   wdata,
    output logic [CTL_W-1:0]   rdata,
    input  logic [N_FLAGS-1:0] tx_flags,
    input  logic [N_FLAGS-1:0] rx_flags,
    output logic               tx_en,
    output logic               rx_en,
    output logic               tx_clk_pol,
    output logic               rx_clk_pol,
    output logic               tx_lsb_first,
    output logic               rx_lsb_first,
    output logic [FS_W:0]      frame_slots,
    output logic [MODE_W-1:0]  pin1_mode,
    output logic [MODE_W-1:0]  pin2_mode,
    output logic [1:0]         pin_oe,
    output logic [1:0]         pin_out,
    output logic               soft_rst,
    output logic               irq
);

    localparam int N_PINS = 2;

    ctl_fields_t fld;

    sport_ctl_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wdata      (wdata),
        .fields     (fld),
        .srst_pulse (soft_rst)
    );

    sport_irq_merge #(.N_FLAGS(N_FLAGS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_ie    (fld.tx_ie),
        .rx_ie    (fld.rx_ie),
        .tx_flags (tx_flags),
        .rx_flags (rx_flags),
        .irq      (irq)
    );

    sport_gpo_pins #(.N_PINS(N_PINS), .MODE_W(MODE_W), .GPO_MODE(GPO_MODE)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_vec ({fld.p2_mode, fld.p1_mode}),
        .val_vec  ({fld.p2_val, fld.p1_val}),
        .oe       (pin_oe),
        .out      (pin_out)
    );

    always_comb begin
        rdata                = '0;
        rdata[FLD_HI:FLD_LO] = fld;
        tx_en                = fld.tx_en;
        rx_en                = fld.rx_en;
        tx_clk_pol           = fld.tx_pol;
        rx_clk_pol           = fld.rx_pol;
        tx_lsb_first         = fld.tx_lsb;
        rx_lsb_first         = fld.rx_lsb;
        frame_slots          = decode_slots(fld.fsize);
        pin1_mode            = fld.p1_mode;
        pin2_mode            = fld.p2_mode;
    end

endmodule

// File: tb/sport_ctl_tb.sv
module sport_ctl_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_VAL = 32'h00F0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [2:0]  tx_flags = '0;
    logic [2:0]  rx_flags = '0;
    logic        tx_en, rx_en, tx_clk_pol, rx_clk_pol, tx_lsb_first, rx_lsb_first;
    logic [4:0]  frame_slots;
    logic [1:0]  pin1_mode, pin2_mode, pin_oe, pin_out;
    logic        soft_rst, irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [48:0] v;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] reg_m = RST_VAL;

    always #(CLK_PERIOD/2) clk = ~clk;

    sport_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .tx_flags(tx_flags), .rx_flags(rx_flags),
        .tx_en(tx_en), .rx_en(rx_en), .tx_clk_pol(tx_clk_pol), .rx_clk_pol(rx_clk_pol),
        .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first),
        .frame_slots(frame_slots), .pin1_mode(pin1_mode), .pin2_mode(pin2_mode),
        .pin_oe(pin_oe), .pin_out(pin_out), .soft_rst(soft_rst), .irq(irq)
    );

    function automatic logic [48:0] model_out(input logic [31:0] r, input logic pulse,
                                              input logic [2:0] txf, input logic [2:0] rxf);
        logic [4:0] slots;
        logic       oe1, oe2, irq_m;
        slots = (r[15:12] == 4'd0) ? 5'd16 : {1'b0, r[15:12]};
        irq_m = (r[17] && (|txf)) || (r[16] && (|rxf));
        oe1   = (r[23:22] == 2'b01);
        oe2   = (r[21:20] == 2'b01);
        return {r, pulse, irq_m, r[29], r[28], r[27], r[26], r[25], r[24], slots,
                oe2, oe1, oe2 && r[18], oe1 && r[19]};
    endfunction

    task automatic step(input logic wr, input logic [31:0] d,
                        input logic [2:0] txf, input logic [2:0] rxf, input string tag);
        exp_t e;
        logic pulse;
        @(negedge clk);
        wr_en    = wr;
        wdata    = d;
        tx_flags = txf;
        rx_flags = rxf;
        @(posedge clk);
        pulse = 1'b0;
        if (wr) begin
            if (d[31] && d[30]) begin
                reg_m = RST_VAL;
                pulse = 1'b1;
            end else begin
                reg_m = d & 32'h3FFF_F000;
            end
        end
        e.v   = model_out(reg_m, pulse, txf, rxf);
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare every expected item away from the clock edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t        e;
                logic [48:0] act;
                e   = sb.pop_front();
                act = {rdata, soft_rst, irq, tx_en, rx_en, tx_clk_pol, rx_clk_pol,
                       tx_lsb_first, rx_lsb_first, frame_slots, pin_oe, pin_out};
                checks++;
                if (act !== e.v) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.v);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 32'h0, 3'b000, 3'b000, "R1 reset value");
        step(1'b0, 32'h0, 3'b111, 3'b111, "R1 no irq after reset");

        step(1'b1, 32'h3FFF_FFFF, 3'b000, 3'b000, "R2 all live bits, reserved read zero");
        step(1'b0, 32'hDEAD_BEEF, 3'b000, 3'b000, "R2 hold without write");
        step(1'b1, 32'h2A00_0000, 3'b000, 3'b000, "R5 transmit side bits");
        step(1'b1, 32'h1500_0000, 3'b000, 3'b000, "R5 receive side bits");

        step(1'b1, 32'h0000_0000, 3'b000, 3'b000, "R6 field zero gives 16");
        step(1'b1, 32'h0000_1000, 3'b000, 3'b000, "R6 field one");
        step(1'b1, 32'h0000_F000, 3'b000, 3'b000, "R6 field fifteen");

        step(1'b1, 32'h0058_0000, 3'b000, 3'b000, "R7 both pins output, pin1 high");
        step(1'b1, 32'h0054_0000, 3'b000, 3'b000, "R7 both pins output, pin2 high");
        step(1'b1, 32'h00AC_0000, 3'b000, 3'b000, "R7 other modes keep pins off");
        step(1'b1, 32'h003C_0000, 3'b000, 3'b000, "R7 mode zero keeps pins off");

        step(1'b1, 32'h0002_0000, 3'b001, 3'b000, "R8 empty flag enabled");
        step(1'b0, 32'h0, 3'b010, 3'b000, "R8 underrun flag enabled");
        step(1'b0, 32'h0, 3'b100, 3'b000, "R8 framing flag enabled");
        step(1'b0, 32'h0, 3'b000, 3'b111, "R8 receive flags ignored by tx enable");
        step(1'b1, 32'h0001_0000, 3'b111, 3'b000, "R9 transmit flags ignored by rx enable");
        step(1'b0, 32'h0, 3'b000, 3'b001, "R9 full flag enabled");
        step(1'b0, 32'h0, 3'b000, 3'b010, "R9 overrun flag enabled");
        step(1'b0, 32'h0, 3'b000, 3'b100, "R9 framing flag enabled");
        step(1'b1, 32'h0003_0000, 3'b010, 3'b000, "R10 tx group alone");
        step(1'b0, 32'h0, 3'b000, 3'b100, "R10 rx group alone");
        step(1'b0, 32'h0, 3'b000, 3'b000, "R10 no flags");

        step(1'b1, 32'h8002_3000, 3'b000, 3'b000, "R4 bit31 alone no pulse");
        step(1'b1, 32'h4002_5000, 3'b001, 3'b000, "R4 bit30 alone no pulse");

        // Reset write while an enabled transmit flag is pending
        step(1'b0, 32'h0, 3'b001, 3'b000, "R8 pending before reset");
        step(1'b1, 32'hEA03_7000, 3'b001, 3'b000, "R3 dual write pulse, irq drops");
        step(1'b0, 32'h0, 3'b001, 3'b000, "R3 pulse ends after one cycle");
        step(1'b1, 32'hC000_0000, 3'b000, 3'b000, "R3 back to back first");
        step(1'b1, 32'hC000_0000, 3'b000, 3'b000, "R3 back to back second");
        step(1'b0, 32'h0, 3'b000, 3'b000, "R3 pulse cleared");

        @(negedge clk);
        wr_en = 1'b0;
        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule